// File: doc/BRIEF.md
# System Clock Source Controller with Crystal Failover

This block picks the source of the system clock from five candidates: the high-speed internal RC oscillator, the low-speed internal RC oscillator, the PLL output, the low-speed crystal and the high-speed crystal. Software writes a 3-bit select code. The block holds the effective selection that a downstream glitch-free mux would follow. The block runs on the reference clock, which is the high-speed internal RC. The analog switching cells and the PLL itself are outside the block.

Each crystal has its own monitor. The monitor brings the raw crystal waveform into the reference domain through synchronizers and counts its rising edges over fixed windows. A crystal that shows no edge for a whole window is declared failed. A crystal is reported stable after a programmable number of consecutive healthy windows. A failed high-speed crystal sets a sticky flag and can raise an interrupt. If that crystal is feeding the system clock, directly or as the PLL reference, the selection is forced to the high-speed internal RC. A low-speed crystal failure only sets its flag and its interrupt.

A divider with ratio 1/(N+1) follows the selection and produces a bus-clock tick. N is a 4-bit field.

Top module: `sysclk_src_ctrl`

## Requirements
- R1: After reset, the effective select is 111, both failure flags are 0, the interrupt is 0 and both stable bits are 0.
- R2: A write of a legal code updates the effective select on the clock edge that samples the write. The legal codes are 000 (high-speed crystal), 001 (low-speed crystal), 010 (PLL), 011 (low-speed RC) and 111 (high-speed RC).
- R3: A write of 100, 101 or 110 leaves the effective select unchanged.
- R4: A write of 000 is ignored while the high-speed crystal stable bit is 0. A write of 010 is ignored while that bit is 0 and the PLL reference is the high-speed crystal. A write of 001 is ignored while the low-speed crystal stable bit is 0.
- R5: A crystal's stable bit becomes 1 only while the crystal is enabled, and only after the programmed number of consecutive windows of WIN reference cycles that each contain a synchronized rising edge. It is cleared by disabling the crystal or by any window with no edge.
- R6: With the crystal enabled and its detector enabled, a window with no edge sets that crystal's failure flag. The flag then stays set.
- R7: A high-speed crystal failure forces the effective select to 111 when the select is 000, or when it is 010 with the PLL reference on the high-speed crystal. In every other case the select is kept.
- R8: A low-speed crystal failure sets its flag and never changes the effective select.
- R9: A clear pulse for a flag resets it to 0. A failure in the same cycle wins over the clear.
- R10: The interrupt is registered. It equals the OR, over both crystals, of the failure flag AND the interrupt enable, one cycle after the flags.
- R11: The high-speed RC enable output is the software enable OR the high-speed detector enable, registered.
- R12: The bus tick pulses once every div_n+1 reference cycles, for every value of div_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (high-speed internal RC) |
| rst | input | 1 | Synchronous active-high reset |
| hxt_in | input | 1 | Raw high-speed crystal waveform |
| lxt_in | input | 1 | Raw low-speed crystal waveform |
| hxt_en | input | 1 | High-speed crystal enable |
| lxt_en | input | 1 | Low-speed crystal enable |
| hxt_det_en | input | 1 | High-speed failure detector enable |
| lxt_det_en | input | 1 | Low-speed failure detector enable |
| hxt_irq_en | input | 1 | High-speed failure interrupt enable |
| lxt_irq_en | input | 1 | Low-speed failure interrupt enable |
| hirc_en_sw | input | 1 | Software request for the high-speed RC |
| pll_ref_hxt | input | 1 | 1 when the PLL reference is the high-speed crystal |
| stb_win | input | STBW | Consecutive healthy windows needed for the stable bit |
| sel_wr | input | 1 | Select write strobe |
| sel_wdata | input | 3 | Select code to write |
| hxt_flag_clr | input | 1 | Clear pulse for the high-speed failure flag |
| lxt_flag_clr | input | 1 | Clear pulse for the low-speed failure flag |
| div_n | input | DIVW | Bus divider value N (ratio 1/(N+1)) |
| sel_eff | output | 3 | Effective clock source select |
| hirc_en | output | 1 | High-speed RC enable |
| hxt_stable | output | 1 | High-speed crystal stable |
| lxt_stable | output | 1 | Low-speed crystal stable |
| hxt_fail_flag | output | 1 | Sticky high-speed failure flag |
| lxt_fail_flag | output | 1 | Sticky low-speed failure flag |
| irq | output | 1 | Failure interrupt |
| bus_tick | output | 1 | Bus clock enable tick |

## Verification
The bench builds the block with WIN=8, STBW=4 and DIVW=4, and programs three healthy windows for the stable bit. The short window lets a stopped crystal be detected, and a recovery be completed, within a few dozen cycles. That allows every failover case to be run in turn: direct selection, selection through the PLL, an unrelated source, the PLL on another reference, and the low-speed crystal. All eight select codes are swept. All sixteen divider values are swept, and each measured tick interval is compared with N+1.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam logic [2:0] SRC_HXT  = 3'b000;
  localparam logic [2:0] SRC_LXT  = 3'b001;
  localparam logic [2:0] SRC_PLL  = 3'b010;
  localparam logic [2:0] SRC_LIRC = 3'b011;
  localparam logic [2:0] SRC_HIRC = 3'b111;

  function automatic logic code_reserved(input logic [2:0] c);
    return (c == 3'b100) || (c == 3'b101) || (c == 3'b110);
  endfunction
endpackage

// File: rtl/xtal_monitor.sv
module xtal_monitor #(
  parameter int WIN  = 64,
  parameter int STBW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xin,
  input  logic            xen,
  input  logic            det_en,
  input  logic [STBW-1:0] stb_win,
  output logic            fail,
  output logic            stable
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [2:0]      sync_q;
  logic            rise;
  logic [CW-1:0]   cnt_q;
  logic            seen_q;
  logic [STBW-1:0] good_q;
  logic [STBW:0]   good_inc;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], xin};
  end

  assign rise     = sync_q[1] & ~sync_q[2];
  assign good_inc = {1'b0, good_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !xen) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      good_q <= '0;
      stable <= 1'b0;
      fail   <= 1'b0;
    end else begin
      fail <= 1'b0;
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        seen_q <= 1'b0;
        if (seen_q || rise) begin
          if (good_q != '1) good_q <= good_inc[STBW-1:0];
          if (good_inc >= {1'b0, stb_win}) stable <= 1'b1;
        end else begin
          good_q <= '0;
          stable <= 1'b0;
          fail   <= det_en;
        end
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        seen_q <= seen_q | rise;
      end
    end
  end

  // R5
  stable_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !xen |=> !stable);
  // R6
  fail_needs_det_chk: assert property (@(posedge clk) disable iff (rst)
    fail |-> $past(det_en));
endmodule

// File: rtl/bus_div_tick.sv
module bus_div_tick #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] div_n,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= div_n) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end

  // R12
  div_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (div_n == '0) && $past(div_n == '0) |=> tick);
endmodule

// File: rtl/sysclk_src_ctrl.sv
module sysclk_src_ctrl
  import sysclk_pkg::*;
#(
  parameter int WIN  = 64,
  parameter int STBW = 4,
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hxt_in,
  input  logic            lxt_in,
  input  logic            hxt_en,
  input  logic            lxt_en,
  input  logic            hxt_det_en,
  input  logic            lxt_det_en,
  input  logic            hxt_irq_en,
  input  logic            lxt_irq_en,
  input  logic            hirc_en_sw,
  input  logic            pll_ref_hxt,
  input  logic [STBW-1:0] stb_win,
  input  logic            sel_wr,
  input  logic [2:0]      sel_wdata,
  input  logic            hxt_flag_clr,
  input  logic            lxt_flag_clr,
  input  logic [DIVW-1:0] div_n,
  output logic [2:0]      sel_eff,
  output logic            hirc_en,
  output logic            hxt_stable,
  output logic            lxt_stable,
  output logic            hxt_fail_flag,
  output logic            lxt_fail_flag,
  output logic            irq,
  output logic            bus_tick
);
  localparam int NX = 2; // index 0: high-speed crystal, 1: low-speed crystal

  logic [NX-1:0] x_in, x_en, x_det, x_fail, x_stb;

  assign x_in  = {lxt_in, hxt_in};
  assign x_en  = {lxt_en, hxt_en};
  assign x_det = {lxt_det_en, hxt_det_en};

  for (genvar i = 0; i < NX; i++) begin : g_mon
    xtal_monitor #(.WIN(WIN), .STBW(STBW)) u_mon (
      .clk(clk), .rst(rst), .xin(x_in[i]), .xen(x_en[i]), .det_en(x_det[i]),
      .stb_win(stb_win), .fail(x_fail[i]), .stable(x_stb[i])
    );
  end

  assign hxt_stable = x_stb[0];
  assign lxt_stable = x_stb[1];

  logic [2:0] sel_q;
  logic       hxt_drives, failover, wr_ok;

  assign hxt_drives = (sel_q == SRC_HXT) || ((sel_q == SRC_PLL) && pll_ref_hxt);
  assign failover   = x_fail[0] && hxt_drives;

  always_comb begin
    wr_ok = sel_wr && !code_reserved(sel_wdata);
    if (sel_wdata == SRC_HXT && !x_stb[0]) wr_ok = 1'b0;
    if (sel_wdata == SRC_LXT && !x_stb[1]) wr_ok = 1'b0;
    if (sel_wdata == SRC_PLL && pll_ref_hxt && !x_stb[0]) wr_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)           sel_q <= SRC_HIRC;
    else if (failover) sel_q <= SRC_HIRC;
    else if (wr_ok)    sel_q <= sel_wdata;
  end

  assign sel_eff = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hxt_fail_flag <= 1'b0;
      lxt_fail_flag <= 1'b0;
      irq           <= 1'b0;
      hirc_en       <= 1'b0;
    end else begin
      if (x_fail[0])         hxt_fail_flag <= 1'b1;
      else if (hxt_flag_clr) hxt_fail_flag <= 1'b0;
      if (x_fail[1])         lxt_fail_flag <= 1'b1;
      else if (lxt_flag_clr) lxt_fail_flag <= 1'b0;
      irq     <= (hxt_fail_flag & hxt_irq_en) | (lxt_fail_flag & lxt_irq_en);
      hirc_en <= hirc_en_sw | hxt_det_en;
    end
  end

  bus_div_tick #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst(rst), .div_n(div_n), .tick(bus_tick)
  );

  // R7
  failover_chk: assert property (@(posedge clk) disable iff (rst)
    x_fail[0] && ((sel_eff == SRC_HXT) || (sel_eff == SRC_PLL && pll_ref_hxt))
      |=> sel_eff == SRC_HIRC);
  // R3
  reserved_keep_chk: assert property (@(posedge clk) disable iff (rst)
    sel_wr && code_reserved(sel_wdata) && !x_fail[0] |=> $stable(sel_eff));
  // R8
  lxt_no_switch_chk: assert property (@(posedge clk) disable iff (rst)
    x_fail[1] && !x_fail[0] && !sel_wr |=> $stable(sel_eff));
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    hxt_fail_flag && !hxt_flag_clr |=> hxt_fail_flag);
  // R11
  hirc_force_chk: assert property (@(posedge clk) disable iff (rst)
    hxt_det_en |=> hirc_en);
  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !hxt_fail_flag && !lxt_fail_flag |=> !irq);
endmodule

// File: tb/sysclk_src_ctrl_bench.sv
module sysclk_src_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8;
  localparam int STBW = 4;
  localparam int DIVW = 4;
  localparam int STB = 3;

  logic clk = 0, rst = 1;
  logic hxt_in = 0, lxt_in = 0, hxt_run = 0, lxt_run = 0;
  logic hxt_en = 0, lxt_en = 0, hxt_det_en = 0, lxt_det_en = 0;
  logic hxt_irq_en = 0, lxt_irq_en = 0, hirc_en_sw = 0, pll_ref_hxt = 0;
  logic [STBW-1:0] stb_win = STBW'(STB);
  logic sel_wr = 0;
  logic [2:0] sel_wdata = 0;
  logic hxt_flag_clr = 0, lxt_flag_clr = 0;
  logic [DIVW-1:0] div_n = 0;
  logic [2:0] sel_eff;
  logic hirc_en, hxt_stable, lxt_stable, hxt_fail_flag, lxt_fail_flag, irq, bus_tick;
  int n_chk = 0, n_bad = 0;

  sysclk_src_ctrl #(.WIN(WIN), .STBW(STBW), .DIVW(DIVW)) u_sysclk_src_ctrl (
    .clk(clk), .rst(rst), .hxt_in(hxt_in), .lxt_in(lxt_in), .hxt_en(hxt_en),
    .lxt_en(lxt_en), .hxt_det_en(hxt_det_en), .lxt_det_en(lxt_det_en),
    .hxt_irq_en(hxt_irq_en), .lxt_irq_en(lxt_irq_en), .hirc_en_sw(hirc_en_sw),
    .pll_ref_hxt(pll_ref_hxt), .stb_win(stb_win), .sel_wr(sel_wr),
    .sel_wdata(sel_wdata), .hxt_flag_clr(hxt_flag_clr), .lxt_flag_clr(lxt_flag_clr),
    .div_n(div_n), .sel_eff(sel_eff), .hirc_en(hirc_en), .hxt_stable(hxt_stable),
    .lxt_stable(lxt_stable), .hxt_fail_flag(hxt_fail_flag),
    .lxt_fail_flag(lxt_fail_flag), .irq(irq), .bus_tick(bus_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always begin #7;  if (hxt_run) hxt_in = ~hxt_in; end
  always begin #23; if (lxt_run) lxt_in = ~lxt_in; end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_sel(logic [2:0] code);
    sel_wdata = code; sel_wr = 1;
    @(negedge clk);
    sel_wr = 0;
  endtask

  task automatic clr_hxt();
    hxt_flag_clr = 1; @(negedge clk); hxt_flag_clr = 0;
  endtask

  // stop the high-speed crystal from a start source, check the outcome, recover
  task automatic hxt_case(logic [2:0] start, logic pll, logic [2:0] exp_sel, logic ien);
    pll_ref_hxt = pll; hxt_irq_en = ien;
    wr_sel(start);
    check("R2 start select", sel_eff, start);
    hxt_run = 0;
    cyc(3*WIN + 6);
    check("R7 select after failure", sel_eff, exp_sel);
    check("R6 flag set", hxt_fail_flag, 1);
    check("R10 irq follows enable", irq, ien);
    check("R5 stable dropped", hxt_stable, 0);
    wr_sel(3'b000);
    check("R4 write ignored while unstable", sel_eff, exp_sel);
    hxt_en = 0; cyc(2);
    clr_hxt(); cyc(2);
    check("R9 flag cleared", hxt_fail_flag, 0);
    check("R10 irq cleared", irq, 0);
    hxt_run = 1; hxt_en = 1;
    cyc(2);
    check("R5 not stable early", hxt_stable, 0);
    cyc(WIN*(STB+2) + 6);
    check("R5 stable after recovery", hxt_stable, 1);
    wr_sel(3'b111);
  endtask

  initial begin
    cyc(3);
    rst = 0;
    @(negedge clk);
    // R1
    check("R1 select", sel_eff, 7);
    check("R1 hxt flag", hxt_fail_flag, 0);
    check("R1 lxt flag", lxt_fail_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 stable", {hxt_stable, lxt_stable}, 0);
    // R11
    check("R11 hirc off", hirc_en, 0);
    hxt_det_en = 1; cyc(2);
    check("R11 hirc forced by detector", hirc_en, 1);
    hxt_det_en = 0; hirc_en_sw = 1; cyc(2);
    check("R11 hirc by software", hirc_en, 1);
    hirc_en_sw = 0; cyc(2);
    check("R11 hirc off again", hirc_en, 0);
    // R4 before crystals are stable
    pll_ref_hxt = 1;
    wr_sel(3'b000); check("R4 hxt write ignored", sel_eff, 7);
    wr_sel(3'b001); check("R4 lxt write ignored", sel_eff, 7);
    wr_sel(3'b010); check("R4 pll write ignored", sel_eff, 7);
    // R5 bring up both crystals
    hxt_run = 1; lxt_run = 1; cyc(4);
    hxt_en = 1; lxt_en = 1; cyc(2);
    check("R5 hxt not yet stable", hxt_stable, 0);
    cyc(WIN*(STB+2) + 6);
    check("R5 hxt stable", hxt_stable, 1);
    check("R5 lxt stable", lxt_stable, 1);
    // R2/R3 sweep over all select codes
    for (int c = 0; c < 8; c++) begin
      automatic int prev = sel_eff;
      automatic int exp = (c >= 4 && c <= 6) ? prev : c;
      wr_sel(3'(c));
      check((c >= 4 && c <= 6) ? "R3 reserved code" : "R2 legal code", sel_eff, exp);
    end
    // R12 divider sweep
    for (int n = 0; n < 16; n++) begin
      automatic int gap = 0;
      div_n = DIVW'(n);
      cyc(20);
      while (!bus_tick) @(negedge clk);
      @(negedge clk); gap = 1;
      while (!bus_tick) begin @(negedge clk); gap++; end
      check("R12 tick interval", gap, n + 1);
    end
    // R6/R7/R10 failure scenarios
    hxt_det_en = 1; lxt_det_en = 1;
    cyc(WIN*2);
    clr_hxt();
    hxt_case(3'b000, 1'b0, 3'b111, 1'b1);
    hxt_case(3'b010, 1'b1, 3'b111, 1'b0);
    hxt_case(3'b011, 1'b0, 3'b011, 1'b1);
    hxt_case(3'b010, 1'b0, 3'b010, 1'b1);
    // R8 low-speed crystal failure
    lxt_irq_en = 1;
    wr_sel(3'b001);
    check("R8 lxt selected", sel_eff, 1);
    lxt_run = 0;
    cyc(3*WIN + 6);
    check("R8 select kept", sel_eff, 1);
    check("R8 lxt flag", lxt_fail_flag, 1);
    check("R10 irq from lxt", irq, 1);
    check("R8 hxt flag untouched", hxt_fail_flag, 0);
    lxt_en = 0; cyc(2);
    lxt_flag_clr = 1; @(negedge clk); lxt_flag_clr = 0; cyc(2);
    check("R9 lxt flag cleared", lxt_fail_flag, 0);
    check("R10 irq cleared", irq, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule